// File: doc/BRIEF.md
# Outbound Memory Window Decoder

This block sits on the processor side of a host-to-PCI bridge and decides, access by access, whether a processor memory access aimed at the top of the address map is sent on to the PCI bus. The top 256 MiB of the 32-bit map, from 0xF0000000 upward, is cut into 32 fixed windows of 8 MiB each. Window `k` starts at 0xF0000000 + k * 8 MiB, so the window number is simply address bits [27:23].

Two registers steer the decision. The window-enable register has one bit per window. The bridge-control register carries a 2-bit mode field in bits [8:7], and that field acts as a global switch. An access is forwarded only when the switch is on and the bit for its window is set. Window 0 belongs to boot firmware and window 31 to the bridge's own registers, so neither can ever be enabled. A forwarded access keeps its address unchanged on the PCI side. Both registers can be written and read back through a small register port.

Top module: `owd_window_decoder`

## Requirements
- R1: After reset both registers read as zero and no access is forwarded.
- R2: A write with `reg_sel`=0 stores `reg_wdata & 0x7FFFFFFE` into the window-enable register, so bits 0 and 31 always read back as zero. A read with `reg_sel`=0 returns that register.
- R3: A write with `reg_sel`=1 stores all 32 bits of `reg_wdata` into the bridge-control register, and a read with `reg_sel`=1 returns them.
- R4: Forwarding is globally on only when control bits [8:7] equal 2'b01. The codes 2'b00, 2'b10 and 2'b11 forward nothing.
- R5: `in_region` is 1 exactly when `acc_addr[31:28]` is 4'hF. An address below 0xF0000000 is never forwarded.
- R6: `chunk_idx` equals `acc_addr[27:23]` when `in_region` is 1, and 0 otherwise.
- R7: `fwd` equals `acc_valid` AND `in_region` AND global-on AND enable bit [`acc_addr[27:23]`].
- R8: Accesses to window 0 or window 31 are never forwarded, even after 0xFFFFFFFF is written to the enable register.
- R9: `pci_addr` equals `acc_addr` whenever `fwd` is 1, and it is 0 whenever `fwd` is 0.
- R10: A register write changes the decode from the cycle after the write edge. An access in the same cycle as the write is decoded with the old values.
- R11: No access is forwarded while `acc_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 window-enable, 1 bridge-control |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| acc_valid | input | 1 | Processor access present |
| acc_addr | input | 32 | Processor access address |
| fwd | output | 1 | Access is sent on to PCI |
| pci_addr | output | 32 | PCI-side address of a forwarded access |
| chunk_idx | output | 5 | Window number of an in-region address |
| in_region | output | 1 | Address lies at or above 0xF0000000 |

## Verification
Any fault in the stored enable bits shows up in two places. Read-back on `reg_rdata` reveals it in the same cycle that the register is selected. The `fwd` output for any access into the affected window reveals it one edge after the faulty write. A global-switch fault, such as a wrong bit pair or a wrong code being decoded, turns every in-region access wrong at once. A mode sweep with all windows enabled therefore exposes it within a few cycles. A window-index fault moves forwarding to a neighbouring window. Random addresses spread over all 32 windows catch it, as do directed probes at windows 0, 1, 30 and 31.

// File: rtl/owd_pkg.sv
package owd_pkg;

  typedef enum logic {
    SEL_ENABLE  = 1'b0,
    SEL_CONTROL = 1'b1
  } owd_sel_e;

  typedef enum logic [1:0] {
    MODE_OFF0 = 2'b00,
    MODE_FWD  = 2'b01,
    MODE_OFF2 = 2'b10,
    MODE_OFF3 = 2'b11
  } owd_mode_e;

  function automatic logic mode_is_on(input logic [1:0] code);
    return code == MODE_FWD;
  endfunction

endpackage

// File: rtl/owd_regs.sv
module owd_regs
  import owd_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned NUM_CHUNKS = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_we,
  input  logic                  reg_sel,
  input  logic [DATA_W-1:0]     reg_wdata,
  output logic [DATA_W-1:0]     reg_rdata,
  output logic [NUM_CHUNKS-1:0] en_q,
  output logic [DATA_W-1:0]     ctrl_q
);

  // Windows that may ever be switched on: all but the first and the last.
  function automatic logic [NUM_CHUNKS-1:0] writable_mask();
    logic [NUM_CHUNKS-1:0] m;
    m = '1;
    m[0] = 1'b0;
    m[NUM_CHUNKS-1] = 1'b0;
    return m;
  endfunction

  localparam logic [NUM_CHUNKS-1:0] EN_MASK = writable_mask();

  owd_sel_e sel;
  logic     wr_enable;
  logic     wr_control;

  assign sel        = owd_sel_e'(reg_sel);
  assign wr_enable  = reg_we && (sel == SEL_ENABLE);
  assign wr_control = reg_we && (sel == SEL_CONTROL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      ctrl_q <= '0;
    end else begin
      if (wr_enable)  en_q   <= reg_wdata[NUM_CHUNKS-1:0] & EN_MASK;
      if (wr_control) ctrl_q <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (sel == SEL_ENABLE) reg_rdata[NUM_CHUNKS-1:0] = en_q;
    else                   reg_rdata = ctrl_q;
  end

endmodule

// File: rtl/owd_chunk_gate.sv
module owd_chunk_gate
  import owd_pkg::*;
#(
  parameter int unsigned NUM_CHUNKS = 32
) (
  input  logic [NUM_CHUNKS-1:0] en_q,
  input  logic [1:0]            mode,
  output logic                  glob_on,
  output logic [NUM_CHUNKS-1:0] chunk_live
);

  assign glob_on = mode_is_on(mode);

  for (genvar k = 0; k < NUM_CHUNKS; k++) begin : g_chunk
    if (k == 0 || k == NUM_CHUNKS - 1) begin : g_fixed_off
      assign chunk_live[k] = 1'b0;
    end else begin : g_gated
      assign chunk_live[k] = glob_on & en_q[k];
    end
  end

endmodule

// File: rtl/owd_decode.sv
module owd_decode #(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned IDX_W       = 5,
  parameter int unsigned CHUNK_SHIFT = 23,
  parameter int unsigned REGION_TAG  = 15,
  localparam int unsigned NUM_CHUNKS = 1 << IDX_W,
  localparam int unsigned TAG_LSB    = CHUNK_SHIFT + IDX_W,
  localparam int unsigned TAG_W      = ADDR_W - TAG_LSB
) (
  input  logic                  acc_valid,
  input  logic [ADDR_W-1:0]     acc_addr,
  input  logic [NUM_CHUNKS-1:0] chunk_live,
  output logic                  in_region,
  output logic [IDX_W-1:0]      chunk_idx,
  output logic                  fwd,
  output logic [ADDR_W-1:0]     pci_addr
);

  localparam logic [TAG_W-1:0] TAG = TAG_W'(REGION_TAG);

  function automatic logic tag_hit(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:TAG_LSB] == TAG;
  endfunction

  function automatic logic [IDX_W-1:0] window_of(input logic [ADDR_W-1:0] a);
    return a[TAG_LSB-1:CHUNK_SHIFT];
  endfunction

  logic [IDX_W-1:0] raw_idx;

  assign in_region = tag_hit(acc_addr);
  assign raw_idx   = window_of(acc_addr);
  assign chunk_idx = in_region ? raw_idx : '0;
  assign fwd       = acc_valid & in_region & chunk_live[raw_idx];
  assign pci_addr  = fwd ? acc_addr : '0;

endmodule

// File: rtl/owd_window_decoder.sv
module owd_window_decoder #(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned IDX_W       = 5,
  parameter int unsigned CHUNK_SHIFT = 23,
  parameter int unsigned REGION_TAG  = 15,
  parameter int unsigned MODE_LSB    = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              fwd,
  output logic [ADDR_W-1:0] pci_addr,
  output logic [IDX_W-1:0]  chunk_idx,
  output logic              in_region
);

  localparam int unsigned NUM_CHUNKS = 1 << IDX_W;

  logic [NUM_CHUNKS-1:0] en_q;
  logic [DATA_W-1:0]     ctrl_q;
  logic [1:0]            mode;
  logic                  glob_on;
  logic [NUM_CHUNKS-1:0] chunk_live;

  assign mode = ctrl_q[MODE_LSB+1:MODE_LSB];

  owd_regs #(
    .DATA_W     (DATA_W),
    .NUM_CHUNKS (NUM_CHUNKS)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .en_q      (en_q),
    .ctrl_q    (ctrl_q)
  );

  owd_chunk_gate #(
    .NUM_CHUNKS (NUM_CHUNKS)
  ) u_gate (
    .en_q       (en_q),
    .mode       (mode),
    .glob_on    (glob_on),
    .chunk_live (chunk_live)
  );

  owd_decode #(
    .ADDR_W      (ADDR_W),
    .IDX_W       (IDX_W),
    .CHUNK_SHIFT (CHUNK_SHIFT),
    .REGION_TAG  (REGION_TAG)
  ) u_dec (
    .acc_valid  (acc_valid),
    .acc_addr   (acc_addr),
    .chunk_live (chunk_live),
    .in_region  (in_region),
    .chunk_idx  (chunk_idx),
    .fwd        (fwd),
    .pci_addr   (pci_addr)
  );

endmodule

// File: rtl/owd_window_checker.sv
module owd_window_checker #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned IDX_W      = 5,
  parameter int unsigned NUM_CHUNKS = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  reg_we,
  input logic                  reg_sel,
  input logic [DATA_W-1:0]     reg_wdata,
  input logic                  acc_valid,
  input logic [ADDR_W-1:0]     acc_addr,
  input logic                  fwd,
  input logic [ADDR_W-1:0]     pci_addr,
  input logic [IDX_W-1:0]      chunk_idx,
  input logic                  in_region,
  input logic [NUM_CHUNKS-1:0] en_q,
  input logic [1:0]            mode,
  input logic                  glob_on
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CHUNKS - 1);

  a_r2_edge_bits_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q[0] && !en_q[NUM_CHUNKS-1]);

  a_r10_enable_update: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !reg_sel) |=> (en_q[NUM_CHUNKS-2:1] == $past(reg_wdata[NUM_CHUNKS-2:1])));

  a_r4_mode_gate: assert property (@(posedge clk) disable iff (!rst_n)
    fwd |-> (mode == 2'b01) && glob_on);

  a_r5_out_of_region: assert property (@(posedge clk) disable iff (!rst_n)
    !in_region |-> !fwd && (chunk_idx == '0));

  a_r8_reserved_windows: assert property (@(posedge clk) disable iff (!rst_n)
    fwd |-> (chunk_idx != '0) && (chunk_idx != LAST_IDX));

  a_r9_addr_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    fwd |-> pci_addr == acc_addr);

  a_r11_valid_needed: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> !fwd && (pci_addr == '0));

  a_r7_enable_needed: assert property (@(posedge clk) disable iff (!rst_n)
    fwd |-> en_q[chunk_idx]);

endmodule

bind owd_window_decoder owd_window_checker #(
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .IDX_W      (IDX_W),
  .NUM_CHUNKS (NUM_CHUNKS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_we    (reg_we),
  .reg_sel   (reg_sel),
  .reg_wdata (reg_wdata),
  .acc_valid (acc_valid),
  .acc_addr  (acc_addr),
  .fwd       (fwd),
  .pci_addr  (pci_addr),
  .chunk_idx (chunk_idx),
  .in_region (in_region),
  .en_q      (en_q),
  .mode      (mode),
  .glob_on   (glob_on)
);

// File: tb/owd_window_decoder_test.sv
module owd_window_decoder_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic        reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        fwd;
  logic [31:0] pci_addr;
  logic [4:0]  chunk_idx;
  logic        in_region;

  int checks = 0;
  int errors = 0;

  // Bench-side register model
  logic [31:0] m_en = '0;
  logic [31:0] m_ctrl = '0;

  always #10 clk = ~clk;

  owd_window_decoder uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .fwd(fwd), .pci_addr(pci_addr),
    .chunk_idx(chunk_idx), .in_region(in_region)
  );

  function automatic logic exp_in(input logic [31:0] a);
    return a >= 32'hF000_0000;
  endfunction

  function automatic logic [4:0] exp_idx(input logic [31:0] a);
    return exp_in(a) ? 5'((a - 32'hF000_0000) / 32'h0080_0000) : 5'd0;
  endfunction

  function automatic logic exp_fwd(input logic v, input logic [31:0] a,
                                   input logic [31:0] en, input logic [31:0] ctl);
    logic [4:0] k;
    k = exp_idx(a);
    return v && exp_in(a) && (ctl[8] == 1'b0) && (ctl[7] == 1'b1)
           && k != 5'd0 && k != 5'd31 && en[k];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Checks all decode outputs against the model for the current inputs.
  task automatic check_decode(input string tag);
    logic ef;
    ef = exp_fwd(acc_valid, acc_addr, m_en, m_ctrl);
    check({"R5 in_region ", tag}, 32'(in_region), 32'(exp_in(acc_addr)));
    check({"R6 chunk_idx ", tag}, 32'(chunk_idx), 32'(exp_idx(acc_addr)));
    check({"R7 fwd ", tag}, 32'(fwd), 32'(ef));
    check({"R9 pci_addr ", tag}, pci_addr, ef ? acc_addr : 32'h0);
  endtask

  // One cycle: drive at the falling edge, check mid low phase, update model at rising edge.
  task automatic cycle(input logic we, input logic sel, input logic [31:0] wd,
                       input logic v, input logic [31:0] a, input string tag);
    @(negedge clk);
    reg_we = we; reg_sel = sel; reg_wdata = wd; acc_valid = v; acc_addr = a;
    #5;
    check_decode(tag);
    check({"R2/R3 readback ", tag}, reg_rdata, sel ? m_ctrl : m_en);
    @(posedge clk);
    if (we) begin
      if (sel) m_ctrl = wd;
      else     m_en = wd & 32'h7FFF_FFFE;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    // R1: reset state
    @(negedge clk);
    reg_sel = 1'b0; #1;
    check("R1 enable after reset", reg_rdata, 32'h0);
    reg_sel = 1'b1; #1;
    check("R1 control after reset", reg_rdata, 32'h0);
    acc_valid = 1'b1; acc_addr = 32'hF100_0000; #1;
    check("R1 no forward after reset", 32'(fwd), 32'h0);
    rst_n = 1'b1;

    // R2: enable mask; R8: reserved windows with everything enabled
    cycle(1'b1, 1'b0, 32'hFFFF_FFFF, 1'b0, 32'h0, "wr en all");
    cycle(1'b0, 1'b0, 32'h0, 1'b0, 32'h0, "R2 readback");
    check("R2 masked enable", reg_rdata, 32'h7FFF_FFFE);
    // R3 + R10: mode on, same cycle access still sees old mode
    cycle(1'b1, 1'b1, 32'hFFFF_FEFF, 1'b1, 32'hF080_0000, "R10 write-cycle");
    check("R10 old mode in write cycle", 32'(fwd), 32'h0);
    cycle(1'b0, 1'b1, 32'h0, 1'b1, 32'hF080_0000, "R10 after write");
    check("R10 new mode next cycle", 32'(fwd), 32'h1);
    check("R3 control readback", reg_rdata, 32'hFFFF_FEFF);
    cycle(1'b0, 1'b0, 32'h0, 1'b1, 32'hF000_0000, "R8 window0");
    check("R8 window 0 blocked", 32'(fwd), 32'h0);
    cycle(1'b0, 1'b0, 32'h0, 1'b1, 32'hFFFF_FFFF, "R8 window31");
    check("R8 window 31 blocked", 32'(fwd), 32'h0);
    cycle(1'b0, 1'b0, 32'h0, 1'b1, 32'hFF7F_FFFC, "R8 window30");
    check("R8 window 30 forwards", 32'(fwd), 32'h1);
    // R11: valid low
    cycle(1'b0, 1'b0, 32'h0, 1'b0, 32'hF400_0000, "R11 invalid");
    check("R11 no forward without valid", 32'(fwd), 32'h0);
    // R5: just below region
    cycle(1'b0, 1'b0, 32'h0, 1'b1, 32'hEFFF_FFFF, "R5 below");
    check("R5 below region", 32'(fwd), 32'h0);
    // R4: sweep mode codes
    for (int c = 0; c < 4; c++) begin
      cycle(1'b1, 1'b1, 32'(c) << 7, 1'b0, 32'h0, "R4 set mode");
      cycle(1'b0, 1'b1, 32'h0, 1'b1, 32'hF880_0000, "R4 probe");
      check("R4 mode code gate", 32'(fwd), (c == 1) ? 32'h1 : 32'h0);
    end

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      logic        we, sel, v;
      logic [31:0] wd, a;
      int          r;
      r   = int'($urandom_range(0, 9));
      we  = (r < 2);
      sel = $urandom_range(0, 1) == 1;
      wd  = $urandom();
      if (sel && $urandom_range(0, 2) != 0) wd[8:7] = 2'b01;
      v   = $urandom_range(0, 7) != 0;
      a   = $urandom();
      if ($urandom_range(0, 3) != 0) a[31:28] = 4'hF;
      cycle(we, sel, wd, v, a, "random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule